// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block clears a wedged two-wire bus before the main bus master takes control of the pins. A slave that was reset or interrupted in the middle of a read can keep the data line low indefinitely, waiting for clock edges that never come. After a go strobe, the sequencer releases both open-drain lines. It then clocks SCL one pulse at a time and samples SDA between pulses. When SDA is seen high, it places a start condition followed by a stop condition on the bus, so every slave returns to a known idle state.

Both line levels pass through two-flop synchronisers before they are used. All phase timing comes from a microsecond tick, produced by a prescaler that counts system clocks. Before each pulse, and before the final start/stop pair, the sequencer waits until SCL actually reads high, so a slave that stretches the clock holds the sequence back. If SDA stays low for the configured number of pulses, the run ends with a failure pulse and both lines released. The top level that hands the pins to the main controller sits outside this block.

Top module: `i2c_bus_clear`

## Requirements
- R1: Out of reset, scl_pull_o, sda_pull_o, busy_o, done_o and fail_o are all 0, and neither line is pulled while busy_o is 0.
- R2: A go_i pulse sampled while idle raises busy_o on that same clock edge. A go_i pulse while busy_o is 1 is ignored, and no second run follows.
- R3: After each release of SCL, and before SDA is examined, the block waits until the synchronised SCL reads high. A slave stretching the clock therefore delays the next pulse, or the start condition, by at least the stretch length.
- R4: Let T = PHASE_US*CLK_PER_US cycles. Each clock pulse has three parts: T cycles with SCL released, then T cycles with SCL pulled low (scl_pull_o=1), then T cycles released. With no stretching, a pull begins 2T+2 cycles after the previous pull ends, and the first pull begins T+2 cycles after busy_o rises.
- R5: Pulses repeat while the synchronised SDA reads low. The number of pulses equals the number of SCL rising edges the slave needs before it releases SDA.
- R6: Once SDA reads high, the block pulls SDA (sda_pull_o=1) 2 cycles after the wait for SCL ends. T cycles later it pulls SCL, T cycles after that it releases SCL, and T cycles after that it releases SDA. SDA changes only while SCL is released.
- R7: done_o is a single-cycle pulse on the edge where SDA is released at the end of the stop, and busy_o falls on that same edge.
- R8: If SDA still reads low after MAX_PULSES pulses, the block returns to idle with a single-cycle fail_o pulse and busy_o falling together. It generates no start/stop, and done_o stays 0.
- R9: During the pulse loop SDA is never pulled, and done_o and fail_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start a recovery run (single-cycle strobe) |
| scl_i | input | 1 | Sampled SCL line level, asynchronous |
| sda_i | input | 1 | Sampled SDA line level, asynchronous |
| scl_pull_o | output | 1 | 1 drives SCL low through the open-drain pad |
| sda_pull_o | output | 1 | 1 drives SDA low through the open-drain pad |
| busy_o | output | 1 | High from go until the run ends |
| done_o | output | 1 | One-cycle pulse when recovery completes |
| fail_o | output | 1 | One-cycle pulse when the pulse limit is reached |

## Verification
The hardest situation to reach is a slave that stretches SCL past the timed release phase and releases SDA on the same delayed rising edge. This tests whether the sequencer re-samples SDA only after SCL is truly high, rather than issuing an extra pulse. The bench models both open-drain lines with a slave that counts rising SCL edges before releasing SDA, and that can hold SCL low for 40 cycles after every master release. Other runs cover a slave that releases after exactly the limit, and one that never releases within it.

// File: rtl/bus_clear_pkg.sv
package bus_clear_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_SCL,
    ST_CHECK,
    ST_PRE,
    ST_LOW,
    ST_HIGH,
    ST_START,
    ST_SCL_LOW,
    ST_SCL_REL
  } clr_state_e;

  function automatic logic is_timed(clr_state_e s);
    return (s == ST_PRE) || (s == ST_LOW) || (s == ST_HIGH) ||
           (s == ST_START) || (s == ST_SCL_LOW) || (s == ST_SCL_REL);
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int CLK_PER_US = 50,
  parameter int PHASE_US   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expire_o
);
  localparam int PW = $clog2(CLK_PER_US + 1);
  localparam int UW = $clog2(PHASE_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(PHASE_US - 1);

  logic [PW-1:0] presc_q;
  logic [UW-1:0] us_q;
  logic          run_q;

  assign expire_o = run_q && (presc_q == PRE_LAST) && (us_q == US_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      us_q    <= '0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      presc_q <= '0;
      us_q    <= '0;
      run_q   <= 1'b1;
    end else if (run_q) begin
      if (presc_q == PRE_LAST) begin
        presc_q <= '0;
        if (us_q == US_LAST) run_q <= 1'b0;
        else                 us_q  <= us_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clear_fsm.sv
module clear_fsm
  import bus_clear_pkg::*;
#(
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic scl_s_i,
  input  logic sda_s_i,
  input  logic expire_i,
  output logic load_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PULSES);

  clr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          done_d, fail_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    case (state_q)
      ST_IDLE:     if (go_i) state_d = ST_WAIT_SCL;
      ST_WAIT_SCL: if (scl_s_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (sda_s_i)              state_d = ST_START;
        else if (cnt_q == CNT_MAX) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else                  state_d = ST_PRE;
      end
      ST_PRE:      if (expire_i) state_d = ST_LOW;
      ST_LOW:      if (expire_i) state_d = ST_HIGH;
      ST_HIGH:     if (expire_i) state_d = ST_WAIT_SCL;
      ST_START:    if (expire_i) state_d = ST_SCL_LOW;
      ST_SCL_LOW:  if (expire_i) state_d = ST_SCL_REL;
      ST_SCL_REL: begin
        if (expire_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  // restart the phase timer on every entry into a timed state
  assign load_o = (state_d != state_q) && is_timed(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      scl_pull_o <= 1'b0;
      sda_pull_o <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go_i)
        cnt_q <= '0;
      else if (state_q == ST_HIGH && expire_i)
        cnt_q <= cnt_q + 1'b1;
      scl_pull_o <= (state_d == ST_LOW) || (state_d == ST_SCL_LOW);
      sda_pull_o <= (state_d == ST_START) || (state_d == ST_SCL_LOW) ||
                    (state_d == ST_SCL_REL);
      busy_o     <= (state_d != ST_IDLE);
      done_o     <= done_d;
      fail_o     <= fail_d;
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int CLK_PER_US = 50,
  parameter int PHASE_US   = 10,
  parameter int MAX_PULSES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic              tmr_load, tmr_expire;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_lines[i]),
      .q_o (sync_lines[i])
    );
  end

  phase_timer #(.CLK_PER_US(CLK_PER_US), .PHASE_US(PHASE_US)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .expire_o (tmr_expire)
  );

  clear_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .go_i       (go_i),
    .scl_s_i    (sync_lines[0]),
    .sda_s_i    (sync_lines[1]),
    .expire_i   (tmr_expire),
    .load_o     (tmr_load),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o)
  );
endmodule

// File: rtl/bus_clear_chk.sv
module bus_clear_chk (
  input logic clk,
  input logic rst,
  input logic go_i,
  input logic scl_pull_o,
  input logic sda_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  // R2
  go_starts_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(go_i));

  // R6
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_o) |-> !scl_pull_o);

  // R6
  stop_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_pull_o) |-> !scl_pull_o);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o || fail_o));

  // R8
  fail_single_chk: assert property (@(posedge clk) disable iff (rst)
    fail_o |=> !fail_o);

  // R9
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));
endmodule

bind i2c_bus_clear bus_clear_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .go_i       (go_i),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;
  localparam int CPU = 4;
  localparam int PUS = 3;
  localparam int MAXP = 5;
  localparam int T = CPU * PUS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic scl_pull, sda_pull, busy, done, fail;
  logic scl_line, sda_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // slave model state
  int  hold_edges = 0;
  int  seen_edges = 0;
  bit  slave_hold = 1'b0;
  int  stretch_len = 0;
  int  stretch_cnt = 0;
  logic prev_scl_line = 1'b1;

  assign scl_line = !(scl_pull || (stretch_cnt > 0));
  assign sda_line = !(sda_pull || slave_hold);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_bus_clear #(.CLK_PER_US(CPU), .PHASE_US(PUS), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst(rst), .go_i(go), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .busy_o(busy),
    .done_o(done), .fail_o(fail)
  );

  // open-drain slave: stretches SCL after the master releases it and
  // releases SDA on its programmed rising edge of the real SCL line
  always @(negedge clk) begin
    if (scl_pull && stretch_len > 0) stretch_cnt = stretch_len;
    else if (stretch_cnt > 0)        stretch_cnt = stretch_cnt - 1;
    if (slave_hold && scl_line && !prev_scl_line) begin
      seen_edges = seen_edges + 1;
      if (seen_edges >= hold_edges) slave_hold = 1'b0;
    end
    prev_scl_line = scl_line;
  end

  typedef struct {
    logic [4:0] val;   // {busy, scl_pull, sda_pull, done, fail}
    int         gap;   // cycles since previous change, -1 = any
    bit         exact; // 0: gap is a lower bound
    string      req;
  } exp_t;

  exp_t q[$];

  task automatic push(logic [4:0] v, int g, bit ex, string r);
    exp_t e;
    e.val = v; e.gap = g; e.exact = ex; e.req = r;
    q.push_back(e);
  endtask

  // monitor
  logic [4:0] prev_v = 5'b0;
  int last_t = 0;
  always @(negedge clk) begin
    logic [4:0] cur;
    cur = {busy, scl_pull, sda_pull, done, fail};
    if (!rst && cur !== prev_v) begin
      int gap;
      gap = cyc - last_t;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected output change actual=%b expected=no change", cur);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (cur !== e.val) begin
          errors++;
          $display("FAIL %s outputs actual=%b expected=%b", e.req, cur, e.val);
        end else if (e.gap >= 0 && ((e.exact && gap != e.gap) ||
                                    (!e.exact && gap < e.gap))) begin
          errors++;
          $display("FAIL %s gap actual=%0d expected=%s%0d", e.req, gap,
                   e.exact ? "" : ">=", e.gap);
        end
      end
      last_t = cyc;
    end
    prev_v = cur;
  end

  // driver: build the expected trace from the requirements, then run
  task automatic run_case(int n, int s, bit extra_go);
    int pulses;
    bit will_fail;
    will_fail = (n > MAXP);
    pulses = will_fail ? MAXP : n;
    push(5'b10000, -1, 1'b1, "R2");
    for (int i = 0; i < pulses; i++) begin
      if (i == 0)      push(5'b11000, T + 2, 1'b1, "R4");
      else if (s == 0) push(5'b11000, 2*T + 2, 1'b1, "R5");
      else             push(5'b11000, s + T, 1'b0, "R3");
      push(5'b10000, T, 1'b1, "R4");
    end
    if (will_fail) begin
      push(5'b00001, T + 2, 1'b1, "R8");
      push(5'b00000, 1, 1'b1, "R8");
    end else begin
      if (pulses == 0)  push(5'b10100, 2, 1'b1, "R6");
      else if (s == 0)  push(5'b10100, T + 2, 1'b1, "R5");
      else              push(5'b10100, s, 1'b0, "R3");
      push(5'b11100, T, 1'b1, "R6");
      push(5'b10100, T, 1'b1, "R6");
      push(5'b00010, T, 1'b1, "R7");
      push(5'b00000, 1, 1'b1, "R7");
    end
    hold_edges = n; seen_edges = 0; slave_hold = (n > 0);
    stretch_len = s;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    if (extra_go) begin
      repeat (30) @(negedge clk);
      go = 1'b1;
      @(negedge clk); go = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (150) @(negedge clk);
    checks++;
    if (busy !== 1'b0 || scl_pull !== 1'b0 || sda_pull !== 1'b0) begin
      errors++;
      $display("FAIL R2 idle after run actual=%b%b%b expected=000", busy, scl_pull, sda_pull);
    end
    slave_hold = 1'b0; stretch_len = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({busy, scl_pull, sda_pull, done, fail} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%b expected=00000",
               {busy, scl_pull, sda_pull, done, fail});
    end
    run_case(0, 0, 1'b0);      // bus already free: start/stop only (R6)
    run_case(3, 0, 1'b1);      // three pulses, extra go ignored (R2, R5)
    run_case(MAXP, 0, 1'b0);   // release on the last allowed pulse (R5)
    run_case(MAXP + 1, 0, 1'b0); // never frees in time (R8)
    run_case(2, 40, 1'b0);     // clock stretching longer than a phase (R3)
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule